// File: doc/BRIEF.md
# Load-Locked Reservation Monitor

This block keeps the reservation state that gives load-locked / store-conditional pairs their meaning when several execution contexts share one memory. Each cycle it accepts at most one memory event, tagged with the issuing context, a physical address and three qualifiers: whether the event is a store, whether it is locked, and whether it targets uncacheable space. A locked load records its address as that context's reservation and arms the context's reservation flag. A locked store (a store-conditional) checks only the issuing context's reservation. The block then returns a result code and a permit that tells the memory path whether the store may be written.

A reservation covers a 16-byte aligned granule, so address bits below bit 4 are ignored in every comparison. Any store that is permitted, whether plain or conditional, disarms the reservation of every context whose granule it hits. This is how a write by one context breaks the pairs that other contexts have open. Each context also counts store-conditional failures in a row. Each time that count reaches a multiple of a fixed period, a one-cycle warning names the context, so that a livelock is made visible.

Top module: `resv_monitor`

## Requirements
- R1: While reset is held, and after it is released, all outputs are low, every reservation flag is disarmed and every failure count is zero.
- R2: A locked load (store=0, locked=1) arms the issuing context's reservation. A cacheable store-conditional to any byte of the same 16-byte granule then gives result code 1 (pass) and permit=1. The result-valid strobe and code appear one cycle after the event.
- R3: A result code of 0 (fail) is never paired with permit=1. The code value 3 is never produced.
- R4: A cacheable store-conditional from a context with no armed reservation gives code 0 and permit=0.
- R5: An uncacheable store-conditional gives code 2 and permit=1 whatever the reservation state, and it sets the issuing context's failure count to zero.
- R6: A permitted store, plain or conditional, disarms the reservation of every context whose granule matches the store address. Reservations on other granules stay armed.
- R7: A failed store-conditional is not permitted, so it leaves other contexts' reservations on that granule armed.
- R8: A passing store-conditional also disarms its own reservation. A second store-conditional without a new locked load fails.
- R9: Each cacheable store-conditional failure adds one to the context's consecutive-failure count, and a pass resets that count. When the count reaches a multiple of WARN_PERIOD, warn_pulse is high for one cycle, together with the result, and warn_ctx names the context.
- R10: Loads and plain stores raise no result strobe, and the code stays 0. A plain store gives permit=1. A load, or a cycle with no event, gives permit=0.
- R11: Reservations are private to each context. A locked load by one context gives no other context a passing store-conditional.
- R12: A new locked load replaces the context's reservation address. A cacheable store-conditional to a different granule fails and disarms the reservation, so a later attempt to the right granule also fails.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_valid | input | 1 | A memory event is present this cycle |
| ev_ctx | input | CTX_W | Issuing context index |
| ev_addr | input | ADDR_W | Physical address of the event |
| ev_store | input | 1 | 1 = store, 0 = load |
| ev_locked | input | 1 | Locked load or store-conditional |
| ev_uncached | input | 1 | Event targets uncacheable space |
| sc_done | output | 1 | Result strobe for a store-conditional |
| sc_code | output | 2 | 0 fail, 1 pass, 2 uncacheable |
| st_permit | output | 1 | Store may be written to memory |
| warn_pulse | output | 1 | Failure-count warning pulse |
| warn_ctx | output | CTX_W | Context that raised the warning |

## Verification
Every output is registered, so the strobe, code, permit and warning for an event are all due on the first clock edge after the edge that captures that event. The bench drives each event at a falling edge and holds it for exactly one rising edge. It then checks that event's results at the next falling edge, where it also drives the following event. Events therefore run back to back, and each check falls in the one cycle its result is valid. Effects on reservation state are seen through later store-conditionals. Effects of reset on the counters are seen through the warning timing.

// File: rtl/resv_pkg.sv
package resv_pkg;
  typedef enum logic [1:0] {
    SC_FAIL     = 2'd0,
    SC_PASS     = 2'd1,
    SC_UNCACHED = 2'd2
  } sc_code_e;
endpackage

// File: rtl/resv_entry.sv
// One context's reservation: granule address plus armed flag.
module resv_entry #(
  parameter int ADDR_W    = 32,
  parameter int GRAN_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [ADDR_W-1:0] set_addr,
  input  logic              clr_en,
  input  logic [ADDR_W-1:0] cmp_addr,
  output logic              flag_o,
  output logic              hit_o
);
  localparam int TAG_W = ADDR_W - GRAN_BITS;

  logic [TAG_W-1:0] tag_q, tag_d;
  logic             flag_q, flag_d;

  // clear applies first, a new reservation overrides it
  always_comb begin
    flag_d = flag_q;
    tag_d  = tag_q;
    if (clr_en) flag_d = 1'b0;
    if (set_en) begin
      flag_d = 1'b1;
      tag_d  = set_addr[ADDR_W-1:GRAN_BITS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      tag_q  <= '0;
    end else begin
      flag_q <= flag_d;
      tag_q  <= tag_d;
    end
  end

  assign flag_o = flag_q;
  assign hit_o  = (tag_q == cmp_addr[ADDR_W-1:GRAN_BITS]);

  // R2: a reservation is armed only by a locked load
  a_r2_arm_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(set_en));
  // R6: a clear without a new set disarms the entry
  a_r6_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !set_en) |=> !flag_q);
endmodule

// File: rtl/resv_fail_ctr.sv
// Consecutive store-conditional failure counter, kept modulo the period.
module resv_fail_ctr #(
  parameter int PERIOD = 100000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fail_en,
  input  logic clr_en,
  output logic wrap_o
);
  localparam int CNT_W = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(PERIOD - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign wrap_o = fail_en && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr_en)       cnt_d = '0;
    else if (fail_en) cnt_d = wrap_o ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R9: after a warning the count restarts from zero
  a_r9_wrap_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (cnt_q == '0));
  // R9: a pass or uncacheable attempt empties the count
  a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> (cnt_q == '0));
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
  import resv_pkg::*;
#(
  parameter int NCTX        = 4,
  parameter int ADDR_W      = 32,
  parameter int GRAN_BITS   = 4,
  parameter int WARN_PERIOD = 100000,
  localparam int CTX_W      = (NCTX > 1) ? $clog2(NCTX) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_valid,
  input  logic [CTX_W-1:0]  ev_ctx,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              ev_store,
  input  logic              ev_locked,
  input  logic              ev_uncached,
  output logic              sc_done,
  output logic [1:0]        sc_code,
  output logic              st_permit,
  output logic              warn_pulse,
  output logic [CTX_W-1:0]  warn_ctx
);
  // asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_s_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_s_n = rst_pipe_q[1];

  logic [NCTX-1:0] flag_w, hit_w, set_w, clr_w, fail_w, pass_w, wrap_w;
  logic            is_sc, is_ll, sc_ok, proceed, sc_fail, sc_clr;

  always_comb begin
    is_sc   = ev_valid && ev_store && ev_locked;
    is_ll   = ev_valid && !ev_store && ev_locked;
    sc_ok   = flag_w[ev_ctx] && hit_w[ev_ctx];
    sc_fail = is_sc && !ev_uncached && !sc_ok;
    sc_clr  = is_sc && (ev_uncached || sc_ok);
    proceed = ev_valid && ev_store && (!ev_locked || ev_uncached || sc_ok);
  end

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    logic own;
    assign own       = (ev_ctx == CTX_W'(c));
    assign set_w[c]  = is_ll && own;
    assign fail_w[c] = sc_fail && own;
    assign pass_w[c] = sc_clr && own;
    assign clr_w[c]  = fail_w[c] || (proceed && hit_w[c]);

    resv_entry #(.ADDR_W(ADDR_W), .GRAN_BITS(GRAN_BITS)) u_entry (
      .clk(clk), .rst_n(rst_s_n),
      .set_en(set_w[c]), .set_addr(ev_addr),
      .clr_en(clr_w[c]), .cmp_addr(ev_addr),
      .flag_o(flag_w[c]), .hit_o(hit_w[c])
    );

    resv_fail_ctr #(.PERIOD(WARN_PERIOD)) u_fail (
      .clk(clk), .rst_n(rst_s_n),
      .fail_en(fail_w[c]), .clr_en(pass_w[c]),
      .wrap_o(wrap_w[c])
    );
  end

  // result registers
  logic             done_d, permit_d, warn_d;
  logic [1:0]       code_d;
  logic             done_q, permit_q, warn_q;
  logic [1:0]       code_q;
  logic [CTX_W-1:0] wctx_q;

  always_comb begin
    done_d   = is_sc;
    permit_d = proceed;
    warn_d   = |wrap_w;
    code_d   = SC_FAIL;
    if (is_sc) begin
      if (ev_uncached) code_d = SC_UNCACHED;
      else if (sc_ok)  code_d = SC_PASS;
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      done_q   <= 1'b0;
      code_q   <= 2'b00;
      permit_q <= 1'b0;
      warn_q   <= 1'b0;
      wctx_q   <= '0;
    end else begin
      done_q   <= done_d;
      code_q   <= code_d;
      permit_q <= permit_d;
      warn_q   <= warn_d;
      if (warn_d) wctx_q <= ev_ctx;
    end
  end

  assign sc_done    = done_q;
  assign sc_code    = code_q;
  assign st_permit  = permit_q;
  assign warn_pulse = warn_q;
  assign warn_ctx   = wctx_q;

  // R3: a failing result never lets the store through
  a_r3_fail_blocks: assert property (@(posedge clk) disable iff (!rst_s_n)
    (sc_done && sc_code == 2'd0) |-> !st_permit);
  // R3: code 3 is never produced
  a_r3_code_legal: assert property (@(posedge clk) disable iff (!rst_s_n)
    sc_done |-> (sc_code != 2'd3));
  // R10: no result strobe means no code
  a_r10_quiet_code: assert property (@(posedge clk) disable iff (!rst_s_n)
    !sc_done |-> (sc_code == 2'd0));
  // R9: a warning only comes with a failed conditional store
  a_r9_warn_with_fail: assert property (@(posedge clk) disable iff (!rst_s_n)
    warn_pulse |-> (sc_done && sc_code == 2'd0));
  // R2: a result follows a store-conditional event by one cycle
  a_r2_result_timing: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ev_valid && ev_store && ev_locked) |=> sc_done);
  // R6: at most one reservation is armed per cycle
  a_r6_single_arm: assert property (@(posedge clk) disable iff (!rst_s_n)
    $onehot0(set_w));
endmodule

// File: tb/resv_monitor_tb.sv
module resv_monitor_tb;
  localparam int NCTX = 4;
  localparam int AW   = 32;
  localparam int CW   = 2;
  localparam int VW   = 46;
  localparam int NV   = 35;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_valid = 1'b0;
  logic [CW-1:0] ev_ctx = '0;
  logic [AW-1:0] ev_addr = '0;
  logic ev_store = 1'b0, ev_locked = 1'b0, ev_uncached = 1'b0;
  logic sc_done, st_permit, warn_pulse;
  logic [1:0] sc_code;
  logic [CW-1:0] warn_ctx;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  resv_monitor #(.NCTX(NCTX), .ADDR_W(AW), .GRAN_BITS(4), .WARN_PERIOD(3)) u_dut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_ctx(ev_ctx),
    .ev_addr(ev_addr), .ev_store(ev_store), .ev_locked(ev_locked),
    .ev_uncached(ev_uncached), .sc_done(sc_done), .sc_code(sc_code),
    .st_permit(st_permit), .warn_pulse(warn_pulse), .warn_ctx(warn_ctx)
  );

  // {req, ctx, addr, store, locked, uncached, exp_done, exp_code, exp_permit, exp_warn}
  localparam logic [VW-1:0] VEC [NV] = '{
    {4'd2,  2'd0, 32'h1000, 1'b0,1'b1,1'b0, 1'b0,2'd0,1'b0,1'b0}, // R2 arm
    {4'd2,  2'd0, 32'h100C, 1'b1,1'b1,1'b0, 1'b1,2'd1,1'b1,1'b0}, // R2 pass
    {4'd8,  2'd0, 32'h1000, 1'b1,1'b1,1'b0, 1'b1,2'd0,1'b0,1'b0}, // R8 consumed
    {4'd12, 2'd1, 32'h2000, 1'b0,1'b1,1'b0, 1'b0,2'd0,1'b0,1'b0}, // R12
    {4'd12, 2'd1, 32'h3000, 1'b0,1'b1,1'b0, 1'b0,2'd0,1'b0,1'b0}, // R12 replace
    {4'd12, 2'd1, 32'h2000, 1'b1,1'b1,1'b0, 1'b1,2'd0,1'b0,1'b0}, // R12 old granule
    {4'd12, 2'd1, 32'h3004, 1'b0,1'b1,1'b0, 1'b0,2'd0,1'b0,1'b0}, // R12
    {4'd12, 2'd1, 32'h3008, 1'b1,1'b1,1'b0, 1'b1,2'd1,1'b1,1'b0}, // R12
    {4'd6,  2'd2, 32'h4000, 1'b0,1'b1,1'b0, 1'b0,2'd0,1'b0,1'b0}, // R6
    {4'd6,  2'd3, 32'h4008, 1'b0,1'b1,1'b0, 1'b0,2'd0,1'b0,1'b0}, // R6
    {4'd6,  2'd0, 32'h5000, 1'b0,1'b1,1'b0, 1'b0,2'd0,1'b0,1'b0}, // R6
    {4'd10, 2'd1, 32'h400F, 1'b1,1'b0,1'b0, 1'b0,2'd0,1'b1,1'b0}, // R10 plain store
    {4'd6,  2'd2, 32'h4000, 1'b1,1'b1,1'b0, 1'b1,2'd0,1'b0,1'b0}, // R6 snooped
    {4'd6,  2'd3, 32'h4000, 1'b1,1'b1,1'b0, 1'b1,2'd0,1'b0,1'b0}, // R6 snooped
    {4'd6,  2'd0, 32'h5000, 1'b1,1'b1,1'b0, 1'b1,2'd1,1'b1,1'b0}, // R6 kept
    {4'd7,  2'd2, 32'h6000, 1'b0,1'b1,1'b0, 1'b0,2'd0,1'b0,1'b0}, // R7
    {4'd4,  2'd3, 32'h6000, 1'b1,1'b1,1'b0, 1'b1,2'd0,1'b0,1'b0}, // R4
    {4'd7,  2'd2, 32'h6000, 1'b1,1'b1,1'b0, 1'b1,2'd1,1'b1,1'b0}, // R7 survived
    {4'd11, 2'd0, 32'h7000, 1'b0,1'b1,1'b0, 1'b0,2'd0,1'b0,1'b0}, // R11
    {4'd11, 2'd1, 32'h7000, 1'b1,1'b1,1'b0, 1'b1,2'd0,1'b0,1'b0}, // R11 other ctx
    {4'd11, 2'd0, 32'h7000, 1'b1,1'b1,1'b0, 1'b1,2'd1,1'b1,1'b0}, // R11 owner
    {4'd5,  2'd0, 32'h8000, 1'b0,1'b1,1'b0, 1'b0,2'd0,1'b0,1'b0}, // R5
    {4'd5,  2'd3, 32'h8000, 1'b1,1'b1,1'b1, 1'b1,2'd2,1'b1,1'b0}, // R5 uncached
    {4'd5,  2'd0, 32'h8000, 1'b1,1'b1,1'b0, 1'b1,2'd0,1'b0,1'b0}, // R5 cleared
    {4'd10, 2'd0, 32'h8000, 1'b0,1'b0,1'b0, 1'b0,2'd0,1'b0,1'b0}, // R10 plain load
    {4'd9,  2'd1, 32'h9000, 1'b1,1'b1,1'b0, 1'b1,2'd0,1'b0,1'b0}, // R9 count 2
    {4'd9,  2'd1, 32'h9000, 1'b1,1'b1,1'b0, 1'b1,2'd0,1'b0,1'b1}, // R9 count 3
    {4'd9,  2'd1, 32'h9000, 1'b1,1'b1,1'b0, 1'b1,2'd0,1'b0,1'b0}, // R9 count 4
    {4'd9,  2'd1, 32'h9000, 1'b0,1'b1,1'b0, 1'b0,2'd0,1'b0,1'b0}, // R9
    {4'd9,  2'd1, 32'h9004, 1'b1,1'b1,1'b0, 1'b1,2'd1,1'b1,1'b0}, // R9 reset
    {4'd9,  2'd1, 32'h9000, 1'b1,1'b1,1'b0, 1'b1,2'd0,1'b0,1'b0}, // R9
    {4'd9,  2'd1, 32'h9000, 1'b1,1'b1,1'b0, 1'b1,2'd0,1'b0,1'b0}, // R9
    {4'd9,  2'd1, 32'h9000, 1'b1,1'b1,1'b0, 1'b1,2'd0,1'b0,1'b1}, // R9 warn
    {4'd5,  2'd3, 32'hA000, 1'b1,1'b1,1'b0, 1'b1,2'd0,1'b0,1'b0}, // R5 count restarted
    {4'd5,  2'd3, 32'hA000, 1'b1,1'b1,1'b0, 1'b1,2'd0,1'b0,1'b0}  // R5 no warn
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_row(input logic [VW-1:0] v);
    string rq;
    rq = $sformatf("R%0d", v[45:42]);
    check(rq, "sc_done", 32'(sc_done), 32'(v[4]));
    check(rq, "sc_code", 32'(sc_code), 32'(v[3:2]));
    check(rq, "st_permit", 32'(st_permit), 32'(v[1]));
    check(rq, "warn_pulse", 32'(warn_pulse), 32'(v[0]));
    if (v[0]) check(rq, "warn_ctx", 32'(warn_ctx), 32'(v[41:40]));
  endtask

  task automatic drive(input logic vld, input logic [CW-1:0] c, input logic [AW-1:0] a,
                       input logic st, input logic lk, input logic uc);
    ev_valid = vld; ev_ctx = c; ev_addr = a;
    ev_store = st; ev_locked = lk; ev_uncached = uc;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    // R1: outputs low in reset
    repeat (3) @(negedge clk);
    check("R1", "sc_done in reset", 32'(sc_done), 0);
    check("R1", "st_permit in reset", 32'(st_permit), 0);
    check("R1", "warn in reset", 32'(warn_pulse), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "sc_done after release", 32'(sc_done), 0);
    check("R1", "sc_code after release", 32'(sc_code), 0);

    for (int i = 0; i < NV; i++) begin
      if (i > 0) check_row(VEC[i-1]);
      drive(1'b1, VEC[i][41:40], VEC[i][39:8], VEC[i][7], VEC[i][6], VEC[i][5]);
      @(negedge clk);
    end
    check_row(VEC[NV-1]);

    // R10: idle cycle
    drive(1'b0, 2'd0, 32'h0, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    check("R10", "idle sc_done", 32'(sc_done), 0);
    check("R10", "idle permit", 32'(st_permit), 0);

    // R1: reset disarms reservations and empties failure counts
    drive(1'b1, 2'd2, 32'hB000, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    drive(1'b0, 2'd0, 32'h0, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", "permit during reset", 32'(st_permit), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    drive(1'b1, 2'd2, 32'hB000, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    drive(1'b0, 2'd0, 32'h0, 1'b0, 1'b0, 1'b0);
    check("R1", "reservation cleared code", 32'(sc_code), 0);
    check("R1", "reservation cleared permit", 32'(st_permit), 0);
    // ctx3 had two failures before reset; one more must not warn
    drive(1'b1, 2'd3, 32'hA000, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    drive(1'b0, 2'd0, 32'h0, 1'b0, 1'b0, 1'b0);
    check("R1", "failure count cleared", 32'(warn_pulse), 0);
    check("R1", "failure strobe", 32'(sc_done), 1);

    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule